// File: doc/BRIEF.md
# Dual-Timebase Capture/Compare Array

This block pairs two 16-bit up-counting time bases, each with its own reload value, with an array of sixteen channel registers. Each channel follows one of the two time bases. In capture mode it records the time at which an edge arrives on its input pin. In one of several compare modes it watches its time base for a chosen value and then raises its interrupt flag, drives its output pin, or does both.

Each time base steps on a tick it takes from one of several sources: a power-of-four division of the system clock, an overflow pulse supplied from outside, a synchronised external count input (time base 0), or the overflow of time base 0 (time base 1, so that the two can be cascaded). The compare modes differ in what the pin does and in how many events one timer period may hold. A single-event option limits a channel to one compare event until software writes its control register again. Software reaches all state through a word-wide register port with a write strobe and a combinational read address.

Top module: `dual_timebase_ccu`

## Requirements
- R1: After reset every readable register returns 0 and every bit of `cc_out` and `irq` is 0.
- R2: The count registers sit at address 32 (base 0) and 34 (base 1), and the reload registers at 33 and 35. On each enabled tick the count rises by one. A tick taken at 0xFFFF loads the reload value instead and produces a one-cycle overflow. A software write to a count takes effect at the next edge and replaces that cycle's tick, without an overflow.
- R3: The time-base control registers sit at 36 and 37: bit 0 is run and bits 3:1 select the source. Sources 0 to 3 divide the system clock by 1, 4, 16 and 64, taken from a free-running 6-bit prescale counter. Source 4 is `aux_ovf`. Source 5 is the rising edge of `ext_cnt` after two synchronising flops for base 0, and the overflow of base 0 for base 1. Sources 6 and 7 never tick.
- R4: The control register of channel n sits at 16+n: bits 2:0 mode, bit 3 time base, bit 4 single-event, bits 6:5 capture edge, and bit 7 armed (read-only, set by every control write). In mode 001 (capture), `cc_in[n]` passes two flops. An edge selected by 01 rising, 10 falling or 11 both copies the chosen count into the value register at address n and sets flag n. A capture overrides a software write in the same cycle.
- R5: A match is the cycle after the chosen time base has stepped to a value equal to the channel's value register. Mode 100 sets the flag on every match and leaves the pin alone.
- R6: Mode 101 toggles the pin and sets the flag on every match.
- R7: Mode 110 sets the flag on the first match of a timer period only. It is re-armed by an overflow of its time base or by a control write. The pin is untouched.
- R8: Mode 111 sets the pin and the flag on the first match of a period. An overflow of its time base clears the pin unless that cycle also holds a permitted match.
- R9: Mode 010 in channel n below 8 toggles pin n and sets flag n on a match of either register n or register n+8 against channel n's time base. In channels 8 to 15 it reacts only to the channel's own register.
- R10: With bit 4 set, the first compare event clears the armed bit. Further compare events in that channel then change neither pin nor flag until control is written again. The overflow clear of mode 111 still acts.
- R11: The flags read at address 38 and are driven on `irq`. Writing a 1 in a bit position clears that flag, but an event in the same cycle wins.
- R12: Bit 3 of the control register selects time base 0 or 1 for both compare and capture.
- Pin and flag changes appear at the clock edge that ends the match or capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |
| cc_in | input | 16 | Channel input pins (capture triggers) |
| cc_out | output | 16 | Channel output pins (compare events) |
| irq | output | 16 | Per-channel interrupt request flags |
| ext_cnt | input | 1 | External count input for time base 0 |
| aux_ovf | input | 1 | Overflow pulse from another timer |

## Verification
A wrong count or reload value moves every match that depends on that time base. The fault shows at `cc_out` and `irq` the clock after the step that should have matched, and shows on `rd_data` as soon as the count is read. A stale once-per-period gate or a stale armed bit surfaces only at the next match in that period: as an extra or missing flag, or as a pin that does not return low on overflow. Capture faults show as a wrong value at the channel's read address once the read sweep reaches it. The reference model predicts every pin, flag and read word on every clock.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

   typedef enum logic [2:0] {
      M_OFF  = 3'b000,
      M_CAP  = 3'b001,
      M_DBL  = 3'b010,
      M_CMP0 = 3'b100,
      M_CMP1 = 3'b101,
      M_CMP2 = 3'b110,
      M_CMP3 = 3'b111
   } ccu_mode_e;

   typedef struct packed {
      logic       armed;
      logic [1:0] edge_sel;
      logic       single;
      logic       tsel;
      ccu_mode_e  mode;
   } ccu_ctrl_t;

endpackage

// File: rtl/ccu_timer.sv
module ccu_timer
   import ccu_pkg::*;
#(
   parameter int TW  = 16,
   parameter int NPS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [2:0]    sel,
   input  logic          aux_tick,
   input  logic          alt_tick,
   input  logic          cnt_we,
   input  logic          rld_we,
   input  logic [TW-1:0] wdata,
   output logic [TW-1:0] cnt,
   output logic [TW-1:0] rld,
   output logic          step,
   output logic          ovf
);
   localparam int PSW = 2 * (NPS - 1);
   localparam int PIW = $clog2(NPS);

   logic [PSW-1:0] pre;
   logic [NPS-1:0] pre_tick;
   logic           tick;

   for (genvar s = 0; s < NPS; s++) begin : g_pre
      localparam logic [PSW-1:0] MASK = PSW'((64'd1 << (2 * s)) - 64'd1);
      assign pre_tick[s] = &(pre | ~MASK);
   end

   always_comb begin
      if (int'(sel) < NPS)           tick = pre_tick[sel[PIW-1:0]];
      else if (int'(sel) == NPS)     tick = aux_tick;
      else if (int'(sel) == NPS + 1) tick = alt_tick;
      else                           tick = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre  <= '0;
         cnt  <= '0;
         rld  <= '0;
         step <= 1'b0;
         ovf  <= 1'b0;
      end else begin
         pre <= pre + 1'b1;
         if (rld_we) rld <= wdata;
         if (cnt_we) begin
            cnt  <= wdata;
            step <= 1'b0;
            ovf  <= 1'b0;
         end else if (run && tick) begin
            step <= 1'b1;
            if (&cnt) begin
               cnt <= rld;
               ovf <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
               ovf <= 1'b0;
            end
         end else begin
            step <= 1'b0;
            ovf  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
   import ccu_pkg::*;
#(
   parameter int TW       = 16,
   parameter bit HAS_PAIR = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctrl_we,
   input  logic                cv_we,
   input  logic                flag_clr,
   input  logic [TW-1:0]       wdata,
   input  logic [1:0][TW-1:0]  t_cnt,
   input  logic [1:0]          t_step,
   input  logic [1:0]          t_ovf,
   input  logic [TW-1:0]       pair_cv,
   input  logic                pin_in,
   output logic [TW-1:0]       cv,
   output ccu_ctrl_t           ctrl,
   output logic                flag,
   output logic                pin,
   output logic                hit,
   output logic                ev,
   output logic                sel_ovf
);
   logic [TW-1:0] tv;
   logic [2:0]    sync;
   logic          st, fired, cap, rise, fall, en, pair_hit, once_ok;

   assign tv      = t_cnt[ctrl.tsel];
   assign st      = t_step[ctrl.tsel];
   assign sel_ovf = t_ovf[ctrl.tsel];

   if (HAS_PAIR) begin : g_pair
      assign pair_hit = (ctrl.mode == M_DBL) && st && (tv == pair_cv);
   end else begin : g_solo
      logic unused_pair;
      assign unused_pair = ^pair_cv;
      assign pair_hit    = 1'b0;
   end

   assign hit     = (st && (tv == cv)) || pair_hit;
   assign en      = !ctrl.single || ctrl.armed;
   assign once_ok = !fired || sel_ovf;
   assign rise    = sync[1] & ~sync[2];
   assign fall    = ~sync[1] & sync[2];
   assign cap     = (ctrl.mode == M_CAP) &&
                    ((ctrl.edge_sel[0] && rise) || (ctrl.edge_sel[1] && fall));

   always_comb begin
      case (ctrl.mode)
         M_CMP0, M_CMP1, M_DBL: ev = hit && en;
         M_CMP2, M_CMP3:        ev = hit && en && once_ok;
         M_CAP:                 ev = cap;
         default:               ev = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync  <= '0;
         cv    <= '0;
         ctrl  <= '0;
         flag  <= 1'b0;
         pin   <= 1'b0;
         fired <= 1'b0;
      end else begin
         sync <= {sync[1:0], pin_in};

         if (cap)        cv <= tv;
         else if (cv_we) cv <= wdata;

         if (ev)            flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;

         if (ctrl_we)
            ctrl <= ccu_ctrl_t'({1'b1, wdata[6:0]});
         else if (ev && ctrl.single && ctrl.mode != M_CAP)
            ctrl.armed <= 1'b0;

         if (ctrl_we)
            fired <= 1'b0;
         else if (ctrl.mode == M_CMP2 || ctrl.mode == M_CMP3) begin
            if (ev)           fired <= 1'b1;
            else if (sel_ovf) fired <= 1'b0;
         end

         case (ctrl.mode)
            M_CMP1, M_DBL: if (ev) pin <= ~pin;
            M_CMP3: begin
               if (ev)           pin <= 1'b1;
               else if (sel_ovf) pin <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dual_timebase_ccu.sv
module dual_timebase_ccu
   import ccu_pkg::*;
#(
   parameter int TW  = 16,
   parameter int NCH = 16,
   parameter int NPS = 4,
   parameter int AW  = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [TW-1:0]  wr_data,
   input  logic [AW-1:0]  rd_addr,
   output logic [TW-1:0]  rd_data,
   input  logic [NCH-1:0] cc_in,
   output logic [NCH-1:0] cc_out,
   output logic [NCH-1:0] irq,
   input  logic           ext_cnt,
   input  logic           aux_ovf
);
   localparam int NTMR  = 2;
   localparam int A_CTL = NCH;
   localparam int A_TMR = 2 * NCH;
   localparam int A_TCT = A_TMR + 2 * NTMR;
   localparam int A_FLG = A_TCT + NTMR;

   if (NCH % 2 != 0 || NCH > TW) begin : g_bad_nch
      $error("NCH must be even and no wider than TW");
   end
   if (TW < 8) begin : g_bad_tw
      $error("TW must hold an 8-bit control word");
   end
   if (A_FLG >= (1 << AW)) begin : g_bad_aw
      $error("AW too small for the register map");
   end
   if (NPS < 2 || NPS + 2 > 8) begin : g_bad_nps
      $error("NPS must leave room for the two pulse sources");
   end

   logic [NTMR-1:0][TW-1:0] t_cnt, t_rld;
   logic [NTMR-1:0]         t_step, t_ovf;
   logic [NTMR-1:0][3:0]    tctl;
   logic [2:0]              xs;
   logic                    ext_rise;

   logic [NCH-1:0][TW-1:0]  cvs;
   ccu_ctrl_t [NCH-1:0]     ctls;
   logic [NCH-1:0]          flags, hits, evs, sel_ovf;

   assign ext_rise = xs[1] & ~xs[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xs   <= '0;
         tctl <= '0;
      end else begin
         xs <= {xs[1:0], ext_cnt};
         for (int t = 0; t < NTMR; t++)
            if (wr_en && wr_addr == AW'(A_TCT + t)) tctl[t] <= wr_data[3:0];
      end
   end

   for (genvar t = 0; t < NTMR; t++) begin : g_tmr
      ccu_timer #(.TW(TW), .NPS(NPS)) u_tmr (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (tctl[t][0]),
         .sel      (tctl[t][3:1]),
         .aux_tick (aux_ovf),
         .alt_tick ((t == 0) ? ext_rise : t_ovf[0]),
         .cnt_we   (wr_en && wr_addr == AW'(A_TMR + 2 * t)),
         .rld_we   (wr_en && wr_addr == AW'(A_TMR + 2 * t + 1)),
         .wdata    (wr_data),
         .cnt      (t_cnt[t]),
         .rld      (t_rld[t]),
         .step     (t_step[t]),
         .ovf      (t_ovf[t])
      );
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [TW-1:0] pcv;
      if (c < NCH / 2) begin : g_hi
         assign pcv = cvs[c + NCH / 2];
      end else begin : g_lo
         assign pcv = cvs[c];
      end
      ccu_channel #(.TW(TW), .HAS_PAIR(c < NCH / 2)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctrl_we  (wr_en && wr_addr == AW'(A_CTL + c)),
         .cv_we    (wr_en && wr_addr == AW'(c)),
         .flag_clr (wr_en && wr_addr == AW'(A_FLG) && wr_data[c]),
         .wdata    (wr_data),
         .t_cnt    (t_cnt),
         .t_step   (t_step),
         .t_ovf    (t_ovf),
         .pair_cv  (pcv),
         .pin_in   (cc_in[c]),
         .cv       (cvs[c]),
         .ctrl     (ctls[c]),
         .flag     (flags[c]),
         .pin      (cc_out[c]),
         .hit      (hits[c]),
         .ev       (evs[c]),
         .sel_ovf  (sel_ovf[c])
      );
   end

   assign irq = flags;

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NCH; c++) begin
         if (rd_addr == AW'(c))         rd_data = cvs[c];
         if (rd_addr == AW'(A_CTL + c)) rd_data = TW'(ctls[c]);
      end
      for (int t = 0; t < NTMR; t++) begin
         if (rd_addr == AW'(A_TMR + 2 * t))     rd_data = t_cnt[t];
         if (rd_addr == AW'(A_TMR + 2 * t + 1)) rd_data = t_rld[t];
         if (rd_addr == AW'(A_TCT + t))         rd_data = TW'(tctl[t]);
      end
      if (rd_addr == AW'(A_FLG)) rd_data = TW'(flags);
   end
endmodule

// File: rtl/ccu_checker.sv
module ccu_checker
   import ccu_pkg::*;
#(
   parameter int TW  = 16,
   parameter int NCH = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0][TW-1:0]  t_cnt,
   input logic [1:0][TW-1:0]  t_rld,
   input logic [1:0]          t_step,
   input logic [1:0]          t_ovf,
   input ccu_ctrl_t [NCH-1:0] ctls,
   input logic [NCH-1:0]      hits,
   input logic [NCH-1:0]      evs,
   input logic [NCH-1:0]      sel_ovf,
   input logic [NCH-1:0]      pins,
   input logic [NCH-1:0]      flags
);
   for (genvar t = 0; t < 2; t++) begin : g_t
      p_wrap_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
         t_ovf[t] |-> (t_step[t] && t_cnt[t] == $past(t_rld[t])));
   end

   for (genvar c = 0; c < NCH; c++) begin : g_c
      p_quiet_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (ctls[c].mode == M_CMP0 || ctls[c].mode == M_CMP2) |=> $stable(pins[c]));

      p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (ctls[c].mode == M_CMP1 && evs[c]) |=> (pins[c] != $past(pins[c])));

      p_period_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (ctls[c].mode == M_CMP3 && sel_ovf[c] && !hits[c]) |=> !pins[c]);

      p_single_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (ctls[c].single && !ctls[c].armed &&
          (ctls[c].mode == M_CMP1 || ctls[c].mode == M_DBL)) |=> $stable(pins[c]));

      p_flag_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flags[c]) |-> $past(evs[c]));
   end
endmodule

bind dual_timebase_ccu ccu_checker #(.TW(TW), .NCH(NCH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .t_cnt   (t_cnt),
   .t_rld   (t_rld),
   .t_step  (t_step),
   .t_ovf   (t_ovf),
   .ctls    (ctls),
   .hits    (hits),
   .evs     (evs),
   .sel_ovf (sel_ovf),
   .pins    (cc_out),
   .flags   (flags)
);

// File: tb/tb_dual_timebase_ccu.sv
module tb_dual_timebase_ccu;
   localparam int TW = 16, NCH = 16, AW = 6;
   localparam int A_CTL = 16, A_TMR = 32, A_TCT = 36, A_FLG = 38;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ext_cnt = 1'b0, aux_ovf = 1'b0;
   logic [AW-1:0]  wr_addr = '0, rd_addr = '0;
   logic [TW-1:0]  wr_data = '0, rd_data;
   logic [NCH-1:0] cc_in = '0, cc_out, irq;

   always #5 clk = ~clk;

   dual_timebase_ccu dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cc_in(cc_in), .cc_out(cc_out),
      .irq(irq), .ext_cnt(ext_cnt), .aux_ovf(aux_ovf));

   int vectors = 0, fails = 0, cyc = 0;
   bit started = 0;

   // behavioural reference state
   int m_pre[2], m_cnt[2], m_rld[2], m_step[2], m_ovf[2], m_tctl[2];
   int e1, e2, e3;
   int m_cv[NCH], m_ctl[NCH], m_flag[NCH], m_pin[NCH], m_fired[NCH];
   int q1[NCH], q2[NCH], q3[NCH];
   int cfg_ctl[NCH], cfg_cv[NCH];

   function automatic void m_reset();
      for (int t = 0; t < 2; t++) begin
         m_pre[t] = 0; m_cnt[t] = 0; m_rld[t] = 0; m_step[t] = 0; m_ovf[t] = 0; m_tctl[t] = 0;
      end
      e1 = 0; e2 = 0; e3 = 0;
      for (int c = 0; c < NCH; c++) begin
         m_cv[c] = 0; m_ctl[c] = 0; m_flag[c] = 0; m_pin[c] = 0; m_fired[c] = 0;
         q1[c] = 0; q2[c] = 0; q3[c] = 0;
      end
   endfunction

   function automatic void m_clock();
      int we, wa, wd;
      int ncnt[2], nstep[2], novf[2];
      we = int'(wr_en); wa = int'(wr_addr); wd = int'(wr_data);
      for (int t = 0; t < 2; t++) begin
         int sel, tick, msk;
         sel = (m_tctl[t] >> 1) & 7;
         tick = 0;
         if (sel < 4) begin
            msk = (1 << (2 * sel)) - 1;
            tick = ((m_pre[t] & msk) == msk) ? 1 : 0;
         end else if (sel == 4) tick = int'(aux_ovf);
         else if (sel == 5) tick = (t == 0) ? ((e2 == 1 && e3 == 0) ? 1 : 0) : m_ovf[0];
         ncnt[t] = m_cnt[t]; nstep[t] = 0; novf[t] = 0;
         if (we == 1 && wa == A_TMR + 2 * t) ncnt[t] = wd;
         else if ((m_tctl[t] & 1) == 1 && tick == 1) begin
            nstep[t] = 1;
            if (m_cnt[t] == 65535) begin ncnt[t] = m_rld[t]; novf[t] = 1; end
            else ncnt[t] = m_cnt[t] + 1;
         end
      end
      for (int c = 0; c < NCH; c++) begin
         int mode, ts, sg, es, armed, tv, st, ov, hit, en, cap, ev;
         mode = m_ctl[c] & 7; ts = (m_ctl[c] >> 3) & 1; sg = (m_ctl[c] >> 4) & 1;
         es = (m_ctl[c] >> 5) & 3; armed = (m_ctl[c] >> 7) & 1;
         tv = m_cnt[ts]; st = m_step[ts]; ov = m_ovf[ts];
         hit = (st == 1 && tv == m_cv[c]) ? 1 : 0;
         if (mode == 2 && c < NCH / 2 && st == 1 && tv == m_cv[c + NCH / 2]) hit = 1;
         en = (sg == 0 || armed == 1) ? 1 : 0;
         cap = 0;
         if (mode == 1 && (((es & 1) != 0 && q2[c] == 1 && q3[c] == 0) ||
                           ((es & 2) != 0 && q2[c] == 0 && q3[c] == 1))) cap = 1;
         ev = 0;
         if (mode == 4 || mode == 5 || mode == 2) ev = hit & en;
         else if (mode == 6 || mode == 7) ev = hit & en & ((m_fired[c] == 0 || ov == 1) ? 1 : 0);
         else if (mode == 1) ev = cap;
         if ((mode == 5 || mode == 2) && ev == 1) m_pin[c] = 1 - m_pin[c];
         if (mode == 7) begin
            if (ev == 1) m_pin[c] = 1;
            else if (ov == 1) m_pin[c] = 0;
         end
         if (we == 1 && wa == A_CTL + c) m_fired[c] = 0;
         else if (mode == 6 || mode == 7) begin
            if (ev == 1) m_fired[c] = 1;
            else if (ov == 1) m_fired[c] = 0;
         end
         if (cap == 1) m_cv[c] = tv;
         else if (we == 1 && wa == c) m_cv[c] = wd;
         if (ev == 1) m_flag[c] = 1;
         else if (we == 1 && wa == A_FLG && ((wd >> c) & 1) == 1) m_flag[c] = 0;
         if (we == 1 && wa == A_CTL + c) m_ctl[c] = (wd & 8'h7F) | 8'h80;
         else if (ev == 1 && sg == 1 && mode != 1) m_ctl[c] = m_ctl[c] & 8'h7F;
         q3[c] = q2[c]; q2[c] = q1[c]; q1[c] = int'(cc_in[c]);
      end
      for (int t = 0; t < 2; t++) begin
         m_cnt[t] = ncnt[t]; m_step[t] = nstep[t]; m_ovf[t] = novf[t];
         if (we == 1 && wa == A_TMR + 2 * t + 1) m_rld[t] = wd;
         if (we == 1 && wa == A_TCT + t) m_tctl[t] = wd & 15;
         m_pre[t] = (m_pre[t] + 1) % 64;
      end
      e3 = e2; e2 = e1; e1 = int'(ext_cnt);
   endfunction

   function automatic int m_read(int a);
      if (a < 16) return m_cv[a];
      if (a < 32) return m_ctl[a - 16];
      if (a == 32) return m_cnt[0];
      if (a == 33) return m_rld[0];
      if (a == 34) return m_cnt[1];
      if (a == 35) return m_rld[1];
      if (a == 36) return m_tctl[0];
      if (a == 37) return m_tctl[1];
      if (a == 38) begin
         int f = 0;
         for (int c = 0; c < NCH; c++) f |= m_flag[c] << c;
         return f;
      end
      return 0;
   endfunction

   function automatic string pin_tag(int c);
      int mode = m_ctl[c] & 7;
      if (!rst_n) return "R1";
      if (((m_ctl[c] >> 4) & 1) == 1) return "R10";
      case (mode)
         5: return "R6";
         6: return "R7";
         7: return "R8";
         2: return "R9";
         default: return "R5";
      endcase
   endfunction

   function automatic string rd_tag(int a);
      if (!rst_n) return "R1";
      if (a < 16) return (((m_ctl[a] >> 3) & 1) == 1) ? "R12" : "R4";
      if (a < 32) return "R10";
      if (a == 32 || a == 33) return (((m_tctl[0] >> 1) & 7) == 0) ? "R2" : "R3";
      if (a == 34 || a == 35) return (((m_tctl[1] >> 1) & 7) == 0) ? "R2" : "R3";
      if (a < 38) return "R3";
      return "R11";
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else m_clock();
      started = 1;
   end

   always @(negedge clk) begin
      if (started) begin
         for (int c = 0; c < NCH; c++) begin
            check(pin_tag(c), 32'(cc_out[c]), 32'(m_pin[c]));
            check(rst_n ? "R11" : "R1", 32'(irq[c]), 32'(m_flag[c]));
         end
         check(rd_tag(int'(rd_addr)), 32'(rd_data), 32'(m_read(int'(rd_addr))));
      end
      rd_addr = (rd_addr == 6'd38) ? 6'd0 : rd_addr + 6'd1;
      cyc++;
      if (cyc > 200000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = TW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      m_reset();
      cfg_ctl = '{16'h05, 16'h07, 16'h04, 16'h06, 16'h02, 16'h15, 16'h0D, 16'h69,
                  16'h21, 16'h41, 16'h1F, 16'h0E, 16'h08, 16'h02, 16'h1A, 16'h4D};
      cfg_cv  = '{16'hFFF5, 16'hFFF8, 16'hFFF2, 16'hFFF2, 16'hFFF3, 16'hFFF4, 16'hFF90, 16'h0,
                  16'h0, 16'h0, 16'hFFA0, 16'hFFC0, 16'hFFFA, 16'hFFF1, 16'hFFB0, 16'hFFE0};
      // R1: reset held long enough for the read sweep to visit every address
      repeat (45) @(negedge clk);
      rst_n = 1'b1;
      wr(A_TMR + 1, 16'hFFF0); wr(A_TMR, 16'hFFF0);
      wr(A_TMR + 3, 16'hFF80); wr(A_TMR + 2, 16'hFF80);
      for (int c = 0; c < NCH; c++) begin
         wr(c, cfg_cv[c]);
         wr(A_CTL + c, cfg_ctl[c]);
      end
      wr(A_TCT, 16'h01);      // R3: base 0 at full rate
      wr(A_TCT + 1, 16'h03);  // R3: base 1 divided by 4
      repeat (300) @(negedge clk);
      for (int i = 0; i < 3500; i++) begin
         int r;
         @(negedge clk);
         cc_in = NCH'($urandom);
         ext_cnt = 1'($urandom);
         aux_ovf = (($urandom % 4) == 0);
         wr_en = 1'b0;
         r = $urandom % 100;
         if (r < 2) begin
            int t = $urandom % 2;
            wr_en = 1'b1; wr_addr = AW'(A_TCT + t); wr_data = TW'((($urandom % 7) << 1) | 1);
         end else if (r < 5) begin
            int t = $urandom % 2;
            wr_en = 1'b1; wr_addr = AW'(A_TMR + 2 * t); wr_data = TW'(16'hFFC0 + $urandom % 64);
         end else if (r < 9) begin
            wr_en = 1'b1; wr_addr = AW'(A_FLG); wr_data = TW'($urandom);
         end else if (r < 12) begin
            int c = $urandom % NCH;
            wr_en = 1'b1; wr_addr = AW'(A_CTL + c); wr_data = TW'(cfg_ctl[c]);
         end else if (r < 13) begin
            int c = $urandom % NCH;
            wr_en = 1'b1; wr_addr = AW'(c); wr_data = TW'(16'hFF80 + $urandom % 128);
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
      repeat (50) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule